// File: doc/BRIEF.md
# Completion Interrupt Coalescing Timer

This block gathers command-completion events from a set of storage ports and turns many of them into one interrupt. Software writes a control word that holds an enable bit, an interrupt index, a completion threshold and a timeout in millisecond units. It also writes a mask that picks which ports take part. Each port supplies a one-cycle completion pulse and a level that says commands are still outstanding on it. A 1 ms tick strobe comes from outside the block.

An interrupt fires when the completion threshold is reached or when the timeout runs out, whichever happens first. The timeout counts down only while at least one selected port has commands outstanding. Each interrupt appears as a one-cycle pulse on `irq_o` together with its index. It also sets the matching bit in a pending vector, which software clears by writing ones. Threshold and timeout values are taken into use only when coalescing is switched on. That way a driver can reprogram the word safely and then restart the feature.

Top module: `ccc_coalesce`

## Requirements
- R1: While control bit 0 (enable) is 0, `irq_o` stays low and the pending vector does not change, whatever completions, busy levels or ticks arrive.
- R2: After reset, `ctrl_o` reads 32'h0001_0100 (threshold 01h in bits 15:8, timeout 0001h in bits 31:16, index 0 in bits 7:3, enable 0). The port mask resets to all zeros.
- R3: The active threshold and timeout are copied from the control word only on a write that takes bit 0 from 0 to 1. A write while enabled shows on `ctrl_o` but leaves the active values unchanged.
- R4: In each cycle, the completion counter adds the number of selected ports that pulse `cmpl_i`, saturating at the active threshold. An interrupt is raised when the counter reaches the threshold.
- R5: An active threshold of 0 disables count-based interrupts.
- R6: The timer loads the timeout on enable. It decrements once per `tick_i` only while some port has both its mask bit and its `busy_i` bit set. An interrupt is raised when it reaches 0. An active timeout of 0 disables timer interrupts.
- R7: Every interrupt, whatever its cause, clears the counter to 0 and reloads the timer with the active timeout.
- R8: When the count and timer conditions hold in the same cycle, exactly one interrupt pulse is produced.
- R9: `irq_idx_o` carries bits 7:3 of the control word with each pulse, and the pending bit at that position is set. `pend_clr_i` clears pending bits by writing ones, and a set in the same cycle wins.
- R10: A mask write takes effect from the next cycle. Ports outside the mask affect neither the counter nor the timer.
- R11: `irq_o` is registered. It is high for the single cycle that follows the clock edge at which the triggering event was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 32 | Control word write data |
| mask_we_i | input | 1 | Port mask write strobe |
| mask_wdata_i | input | NPORT | Port mask write data |
| cmpl_i | input | NPORT | Per-port completion pulse |
| busy_i | input | NPORT | Per-port commands-outstanding level |
| tick_i | input | 1 | One-cycle strobe every millisecond |
| pend_clr_i | input | NVEC | Pending bits to clear (write one to clear) |
| ctrl_o | output | 32 | Current control word |
| irq_o | output | 1 | Coalesced interrupt pulse |
| irq_idx_o | output | 5 | Index carried with the pulse |
| pend_o | output | NVEC | Pending interrupt bits |

## Verification
Several rules are checked by the assertions on every cycle. Disabling silences the interrupt. The counter never passes the active threshold, and it holds when no selected port completes. The timer holds without a qualified tick. Active settings stay frozen except on an enable edge. Every pulse leaves the counter cleared, the timer reloaded and its pending bit set. Only the bench scenarios can show how many events or ticks it takes to reach an interrupt. The same holds for what happens when threshold and timeout tie in one cycle, for the effect of a mask change, and for whether a write while enabled is truly deferred. The bench sweeps thresholds and timeouts over small ranges and compares the position of each interrupt with the programmed value.

// File: rtl/ccc_pkg.sv
package ccc_pkg;
  localparam int CTRL_W  = 32;
  localparam int EN_BIT  = 0;
  localparam int IDX_LSB = 3;
  localparam int IDX_W   = 5;
  localparam int CNT_LSB = 8;
  localparam int CNT_W   = 8;
  localparam int TMO_LSB = 16;
  localparam int TMO_W   = 16;
  localparam logic [CTRL_W-1:0] CTRL_RST = 32'h0001_0100;
endpackage

// File: rtl/ccc_cfg.sv
module ccc_cfg
  import ccc_pkg::*;
#(
  parameter int NPORT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              mask_we_i,
  input  logic [NPORT-1:0]  mask_wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              en_o,
  output logic              rise_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [CNT_W-1:0]  thr_o,
  output logic [TMO_W-1:0]  tv_o,
  output logic [TMO_W-1:0]  tv_load_o,
  output logic [NPORT-1:0]  mask_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  thr_q;
  logic [TMO_W-1:0]  tv_q;
  logic [NPORT-1:0]  mask_q;
  logic [CNT_W-1:0]  w_thr;
  logic [TMO_W-1:0]  w_tmo;

  assign w_thr  = ctrl_wdata_i[CNT_LSB +: CNT_W];
  assign w_tmo  = ctrl_wdata_i[TMO_LSB +: TMO_W];
  assign rise_o = ctrl_we_i & ctrl_wdata_i[EN_BIT] & ~ctrl_q[EN_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      thr_q  <= CTRL_RST[CNT_LSB +: CNT_W];
      tv_q   <= CTRL_RST[TMO_LSB +: TMO_W];
      mask_q <= '0;
    end else begin
      if (ctrl_we_i) ctrl_q <= ctrl_wdata_i;
      if (rise_o) begin
        thr_q <= w_thr;
        tv_q  <= w_tmo;
      end
      if (mask_we_i) mask_q <= mask_wdata_i;
    end
  end

  assign ctrl_o    = ctrl_q;
  assign en_o      = ctrl_q[EN_BIT];
  assign idx_o     = ctrl_q[IDX_LSB +: IDX_W];
  assign thr_o     = thr_q;
  assign tv_o      = tv_q;
  assign tv_load_o = rise_o ? w_tmo : tv_q;
  assign mask_o    = mask_q;

  // settings only move on an enable edge
  assert_act_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_o |=> ($stable(thr_q) && $stable(tv_q)));
endmodule

// File: rtl/ccc_count.sv
module ccc_count #(
  parameter int NPORT = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             fire_i,
  input  logic [NPORT-1:0] hits_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  localparam int SUM_W = CNT_W + $clog2(NPORT + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SUM_W-1:0] inc, sum;
  logic             thr_on;

  always_comb begin
    inc = '0;
    for (int i = 0; i < NPORT; i++) inc = inc + SUM_W'(hits_i[i]);
  end

  assign thr_on = (thr_i != '0);
  assign sum    = SUM_W'(cnt_q) + inc;
  assign hit_o  = en_i && thr_on && (sum >= SUM_W'(thr_i));

  always_comb begin
    if (!en_i || !thr_on || fire_i) cnt_d = '0;
    else if (sum >= SUM_W'(thr_i))  cnt_d = thr_i;
    else                            cnt_d = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_cnt_sat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_i != '0) |-> (cnt_q <= thr_i));
  assert_cnt_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !fire_i && hits_i == '0) |=> $stable(cnt_q));
endmodule

// File: rtl/ccc_timer.sv
module ccc_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic             fire_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [TMO_W-1:0] tv_i,
  output logic [TMO_W-1:0] tmr_o,
  output logic             hit_o
);
  logic [TMO_W-1:0] tmr_q;
  logic             step;

  assign step  = en_i && run_i && tick_i && (tmr_q != '0);
  assign hit_o = step && (tmr_q == TMO_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               tmr_q <= '0;
    else if (load_i || fire_i) tmr_q <= tv_i;
    else if (step)             tmr_q <= tmr_q - TMO_W'(1);
  end

  assign tmr_o = tmr_q;

  assert_tmr_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !fire_i && !(en_i && run_i && tick_i)) |=> $stable(tmr_q));
endmodule

// File: rtl/ccc_coalesce.sv
module ccc_coalesce
  import ccc_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int NVEC  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              mask_we_i,
  input  logic [NPORT-1:0]  mask_wdata_i,
  input  logic [NPORT-1:0]  cmpl_i,
  input  logic [NPORT-1:0]  busy_i,
  input  logic              tick_i,
  input  logic [NVEC-1:0]   pend_clr_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              irq_o,
  output logic [IDX_W-1:0]  irq_idx_o,
  output logic [NVEC-1:0]   pend_o
);
  logic             en, rise, fire, cnt_hit, tmr_hit, run;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] thr, cnt;
  logic [TMO_W-1:0] tv, tv_load, tmr;
  logic [NPORT-1:0] mask;
  logic             irq_q;
  logic [IDX_W-1:0] idx_q;
  logic [NVEC-1:0]  pend_q;

  ccc_cfg #(.NPORT(NPORT)) u_cfg (
    .clk_i, .rst_ni, .ctrl_we_i, .ctrl_wdata_i, .mask_we_i, .mask_wdata_i,
    .ctrl_o, .en_o(en), .rise_o(rise), .idx_o(idx), .thr_o(thr), .tv_o(tv),
    .tv_load_o(tv_load), .mask_o(mask)
  );

  ccc_count #(.NPORT(NPORT), .CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .en_i(en), .fire_i(fire), .hits_i(cmpl_i & mask),
    .thr_i(thr), .cnt_o(cnt), .hit_o(cnt_hit)
  );

  assign run = |(busy_i & mask);

  ccc_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk_i, .rst_ni, .en_i(en), .load_i(rise), .fire_i(fire), .run_i(run),
    .tick_i, .tv_i(tv_load), .tmr_o(tmr), .hit_o(tmr_hit)
  );

  // count and timer hits merge into one event
  assign fire = en & (cnt_hit | tmr_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      idx_q <= '0;
    end else begin
      irq_q <= fire;
      if (fire) idx_q <= idx;
    end
  end

  for (genvar v = 0; v < NVEC; v++) begin : g_pend
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              pend_q[v] <= 1'b0;
      else if (fire && idx == IDX_W'(v))        pend_q[v] <= 1'b1;
      else if (pend_clr_i[v])                   pend_q[v] <= 1'b0;
    end
  end

  assign irq_o     = irq_q;
  assign irq_idx_o = idx_q;
  assign pend_o    = pend_q;

  assert_off_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> !irq_q);
  assert_reload_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> (cnt == '0 && tmr == tv));
  assert_pend_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> pend_q[idx_q]);
endmodule

// File: tb/sim_ccc_coalesce.sv
module sim_ccc_coalesce;
  localparam int NP = 4;
  localparam int NV = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctrl_we = 1'b0;
  logic [31:0]   ctrl_wd = '0;
  logic          mask_we = 1'b0;
  logic [NP-1:0] mask_wd = '0;
  logic [NP-1:0] cmpl = '0;
  logic [NP-1:0] busy = '0;
  logic          tick = 1'b0;
  logic [NV-1:0] pclr = '0;
  logic [31:0]   ctrl_o;
  logic          irq;
  logic [4:0]    irq_idx;
  logic [NV-1:0] pend;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  ccc_coalesce #(.NPORT(NP), .NVEC(NV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd),
    .mask_we_i(mask_we), .mask_wdata_i(mask_wd), .cmpl_i(cmpl), .busy_i(busy),
    .tick_i(tick), .pend_clr_i(pclr), .ctrl_o(ctrl_o), .irq_o(irq),
    .irq_idx_o(irq_idx), .pend_o(pend)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [NP-1:0] c, input logic t, output bit f);
    cmpl = c; tick = t;
    @(negedge clk);
    f = irq;
    cmpl = '0; tick = 1'b0;
  endtask

  task automatic wr(input bit en, input int idx, input int thr, input int tmo);
    ctrl_we = 1'b1;
    ctrl_wd = {16'(tmo), 8'(thr), 5'(idx), 2'b00, en};
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic restart(input int idx, input int thr, input int tmo);
    wr(1'b0, idx, thr, tmo);
    wr(1'b1, idx, thr, tmo);
  endtask

  task automatic set_mask(input logic [NP-1:0] m);
    mask_we = 1'b1; mask_wd = m;
    @(negedge clk);
    mask_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit f;
    int first, nf;
    logic [NV-1:0] p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    chk(ctrl_o == 32'h0001_0100, "R2 ctrl reset", ctrl_o, 32'h0001_0100);
    chk(irq == 1'b0 && pend == '0, "R2 irq/pend reset", {irq, pend}, 0);
    // R10 mask resets to zero: enabled with threshold 1, completions ignored
    restart(0, 1, 0);
    nf = 0;
    for (int k = 0; k < 4; k++) begin cyc(4'hF, 1'b0, f); nf += int'(f); end
    chk(nf == 0, "R10 reset mask selects nothing", nf, 0);

    set_mask(4'hF);
    // R1 disabled
    wr(1'b0, 0, 1, 1);
    busy = 4'hF;
    nf = 0; p0 = pend;
    for (int k = 0; k < 8; k++) begin cyc(4'hF, 1'b1, f); nf += int'(f); end
    chk(nf == 0 && pend == p0, "R1 disabled gives no interrupt", nf, 0);
    busy = '0;

    // R4 R11 threshold sweep, single port each cycle
    for (int thr = 1; thr <= 6; thr++) begin
      restart(0, thr, 0);
      first = 0;
      for (int k = 1; k <= 8; k++) begin
        cyc(4'(1 << (k % 4)), 1'b0, f);
        if (f && first == 0) first = k;
      end
      chk(first == thr, "R4 threshold sweep", first, thr);
    end

    // R4 saturation of simultaneous completions
    restart(0, 3, 0);
    cyc(4'hF, 1'b0, f);
    chk(f == 1'b1, "R4 multi-port saturates to one interrupt", f, 1);
    cyc(4'h1, 1'b0, f); first = int'(f);
    cyc(4'h2, 1'b0, f); first += int'(f);
    cyc(4'h4, 1'b0, f);
    chk(first == 0 && f == 1'b1, "R7 counter cleared after interrupt", {first, f}, 1);

    // R5 threshold zero
    restart(0, 0, 0);
    nf = 0;
    for (int k = 0; k < 20; k++) begin cyc(4'hF, 1'b0, f); nf += int'(f); end
    chk(nf == 0, "R5 zero threshold never fires", nf, 0);

    // R6 R7 timeout sweep
    for (int tv = 1; tv <= 5; tv++) begin
      restart(0, 0, tv);
      busy = 4'h1;
      first = 0; nf = 0;
      for (int k = 1; k <= 2 * tv; k++) begin
        cyc('0, 1'b1, f);
        if (f) begin nf++; if (first == 0) first = k; end
      end
      busy = '0;
      chk(first == tv && nf == 2, "R6 timeout sweep with reload", {first, nf}, {tv, 2});
    end

    // R6 timer frozen without busy; R10 unselected busy ignored
    set_mask(4'h1);
    restart(0, 0, 2);
    nf = 0;
    for (int k = 0; k < 5; k++) begin cyc('0, 1'b1, f); nf += int'(f); end
    busy = 4'h2;
    for (int k = 0; k < 5; k++) begin cyc('0, 1'b1, f); nf += int'(f); end
    chk(nf == 0, "R10 timer needs a selected busy port", nf, 0);
    busy = 4'h1;
    cyc('0, 1'b1, f); first = int'(f);
    cyc('0, 1'b1, f);
    chk(first == 0 && f == 1'b1, "R6 timer fires after full timeout", {first, f}, 1);
    busy = '0;

    // R10 unselected completions ignored; mask change next cycle
    restart(0, 1, 0);
    cyc(4'hE, 1'b0, f);
    chk(f == 1'b0, "R10 unselected completion ignored", f, 0);
    set_mask(4'h4);
    cyc(4'h4, 1'b0, f);
    chk(f == 1'b1, "R10 new mask active next cycle", f, 1);
    set_mask(4'hF);

    // R3 deferred settings
    restart(0, 2, 0);
    wr(1'b1, 0, 5, 0);
    chk(ctrl_o[15:8] == 8'd5, "R3 write shows on ctrl_o", ctrl_o[15:8], 5);
    cyc(4'h1, 1'b0, f); first = int'(f);
    cyc(4'h1, 1'b0, f);
    chk(first == 0 && f == 1'b1, "R3 old threshold kept while enabled", {first, f}, 1);
    restart(0, 5, 0);
    first = 0;
    for (int k = 1; k <= 6; k++) begin cyc(4'h1, 1'b0, f); if (f && first == 0) first = k; end
    chk(first == 5, "R3 new threshold after re-enable", first, 5);

    // R7 count-triggered interrupt reloads timer
    restart(0, 2, 3);
    busy = 4'h1;
    cyc('0, 1'b1, f); cyc('0, 1'b1, f);
    cyc(4'h1, 1'b0, f); cyc(4'h1, 1'b0, f);
    chk(f == 1'b1, "R7 count fire with timer partly run", f, 1);
    first = 0;
    for (int k = 1; k <= 3; k++) begin cyc('0, 1'b1, f); if (f && first == 0) first = k; end
    chk(first == 3, "R7 timer reloaded by count interrupt", first, 3);

    // R8 coincident conditions
    restart(0, 2, 2);
    cyc(4'h1, 1'b0, f); nf = int'(f);
    cyc('0, 1'b1, f);   nf += int'(f);
    cyc(4'h1, 1'b1, f);
    chk(nf == 0 && f == 1'b1, "R8 coincident event fires", {nf, f}, 1);
    cyc('0, 1'b0, f);
    chk(f == 1'b0, "R11 single-cycle pulse", f, 0);
    cyc('0, 1'b1, f); nf = int'(f);
    cyc(4'h1, 1'b0, f); nf += int'(f);
    cyc('0, 1'b1, f);
    chk(nf == 0 && f == 1'b1, "R8 both reset after coincident event", {nf, f}, 1);
    busy = '0;

    // R9 index and pending
    pclr = '1; @(negedge clk); pclr = '0;
    chk(pend == '0, "R9 pending cleared by write-one", pend, 0);
    restart(13, 1, 0);
    cyc(4'h1, 1'b0, f);
    chk(f == 1'b1 && irq_idx == 5'd13, "R9 index carried with pulse", irq_idx, 13);
    chk(pend == (32'h1 << 13), "R9 pending bit set", pend, 32'h1 << 13);
    pclr = 32'h1 << 13;
    cmpl = 4'h1;
    @(negedge clk);
    cmpl = '0; pclr = '0;
    chk(pend[13] == 1'b1, "R9 set wins over clear", pend[13], 1);

    finish_run();
  end
endmodule